// File: doc/BRIEF.md
# I2C Byte-Stream Initiator

This block turns a stream of byte requests into I2C bus activity. Each accepted request moves exactly one byte across the bus. It carries three fields: a direction flag (`in_rd`), a byte to send (`in_data`) and an end-of-transaction flag (`in_last`). The first request after reset or after a STOP is preceded by a START. A request with `in_last` set is followed by a STOP once its acknowledge clock has finished. Between the bytes of one transaction, SCL is held low until the next request arrives.

The target address needs no special field. It is sent as an ordinary write request, with the 7-bit address in bits 7:1 and the bus direction in bit 0. A register read therefore takes two transactions. The first writes the address and the register index and ends with STOP. The second writes the address with bit 0 set, followed by read requests.

Each byte read from the bus appears on `out_data` with a one-cycle `out_valid` pulse, and `out_last` repeats the request's end flag. For a write, the target's acknowledge is sampled and a refusal is reported on `wr_nack`. Both bus lines are open drain: an output-enable of 1 pulls the line low. The SCL period is set by the `PERIOD_CYC` parameter.

Top module: `i2c_byte_stream`

## Requirements
- R1: A request with `in_rd`=0 puts `in_data` on SDA most significant bit first. The target samples that byte, unchanged, on the rising SCL edges of clocks 1 to 8.
- R2: A request with `in_rd`=1 leaves SDA released during data clocks 1 to 8, whatever its `in_data` holds. It captures SDA MSB first and presents the byte on `out_data` with a one-cycle `out_valid` pulse. Write requests never pulse `out_valid`.
- R3: `out_last` accompanying a read byte equals the `in_last` of the request that produced it.
- R4: Before the first byte after reset or after a STOP, the block makes SDA fall while SCL is released high (START). No other START is generated.
- R5: After the ninth clock of a request with `in_last`=1, SDA rises while SCL is high (STOP). Both lines are then left released.
- R6: On the ninth clock of a read request, the block pulls SDA low (ACK) when `in_last`=0 and leaves it released (NACK) when `in_last`=1.
- R7: On a write request, SDA is sampled in the middle of the ninth SCL high time. If it is high, `wr_nack` pulses for one cycle at the end of that byte.
- R8: SDA changes only while SCL is low, except for the START and STOP edges.
- R9: The SCL period is 4·(`PERIOD_CYC`/4) system cycles, and SCL is high for half of it.
- R10: `in_ready` is high only when idle or between bytes. It drops in the cycle after a request is accepted. Between bytes of a transaction, SCL stays pulled low.
- R11: During and after reset both output-enables are 0, `in_ready` is 1 and `out_valid` and `wr_nack` are 0. This holds even if reset arrives in the middle of a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted when high together with `in_valid` |
| in_rd | input | 1 | 1 = read a byte, 0 = write `in_data` |
| in_data | input | 8 | Byte to send (ignored for reads) |
| in_last | input | 1 | End the transaction with STOP after this byte |
| out_valid | output | 1 | One-cycle pulse: a read byte is on `out_data` |
| out_data | output | 8 | Byte read from the bus |
| out_last | output | 1 | Read byte was the final one of its transaction |
| wr_nack | output | 1 | One-cycle pulse: target refused a written byte |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions assume that no other controller or stretching target moves SCL. They also assume that SDA, as seen through `sda_in`, changes only while SCL is low, apart from START and STOP. The bench's target model respects this. It alters its pull-down only on falling SCL edges, and the bench changes the target's per-byte settings only while SCL is held low or the bus is idle. Requests are offered only while `in_ready` is observed high, and `in_last` is set on any write the target refuses.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_ACK,
    ST_HOLD,
    ST_STOP
  } i2cs_state_e;

  // Quarter of the SCL period, never below one cycle.
  function automatic int quarter_cycles(input int period);
    return (period / 4 < 1) ? 1 : period / 4;
  endfunction

  // Line pull-downs {scl_low, sda_low} for a state and quarter phase.
  // Data bits: q0 low, q1-q2 high, q3 low; SDA moves only across q3->q0.
  function automatic logic [1:0] bus_pull(input i2cs_state_e st,
                                          input logic [1:0] qph,
                                          input logic tx_bit,
                                          input logic rd,
                                          input logic last);
    logic scl_low;
    logic sda_low;
    scl_low = 1'b0;
    sda_low = 1'b0;
    unique case (st)
      ST_START: begin
        scl_low = (qph == 2'd3);
        sda_low = (qph >= 2'd2);
      end
      ST_BIT: begin
        scl_low = (qph == 2'd0) || (qph == 2'd3);
        sda_low = !rd && !tx_bit;
      end
      ST_ACK: begin
        scl_low = (qph == 2'd0) || (qph == 2'd3);
        sda_low = rd && !last;
      end
      ST_HOLD: begin
        scl_low = 1'b1;
        sda_low = 1'b0;
      end
      ST_STOP: begin
        scl_low = (qph == 2'd0);
        sda_low = (qph <= 2'd1);
      end
      default: begin
        scl_low = 1'b0;
        sda_low = 1'b0;
      end
    endcase
    return {scl_low, sda_low};
  endfunction

endpackage

// File: rtl/i2cs_qtick.sv
module i2cs_qtick #(
  parameter int QTR = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign tick = run && (cnt == LAST);

  generate
    if (QTR > 1) begin : g_spacing
      // R9: quarters last more than one cycle, so ticks never touch
      a_r9_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/i2cs_shift.sv
module i2cs_shift
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              advance,
  input  logic              sample,
  input  logic              sda_in,
  output logic              tx_msb,
  output logic [BYTE_W-1:0] rx_byte
);

  logic [BYTE_W-1:0] tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (load) begin
      tx_q <= load_byte;
    end else if (advance) begin
      tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_byte <= '0;
    end else if (sample) begin
      rx_byte <= {rx_byte[BYTE_W-2:0], sda_in};
    end
  end

  assign tx_msb = tx_q[BYTE_W-1];

endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              in_valid,
  input  logic              in_rd,
  input  logic              in_last,
  input  logic              sda_in,
  input  logic              tx_msb,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              in_ready,
  output logic              accept,
  output logic              run,
  output logic              advance,
  output logic              sample,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              wr_nack
);

  localparam logic [BIT_CW-1:0] FIRST_BIT = BIT_CW'(BYTE_W - 1);

  i2cs_state_e       st;
  logic [1:0]        qph;
  logic [1:0]        qph_nx;
  logic [BIT_CW-1:0] bcnt;
  logic              cur_rd;
  logic              cur_last;
  logic              ack_hi;
  logic              byte_done;
  logic [1:0]        pull;

  assign qph_nx    = qph + 2'd1;
  assign in_ready  = (st == ST_IDLE) || (st == ST_HOLD);
  assign accept    = in_valid && in_ready;
  assign run       = !in_ready;
  assign advance   = tick && (st == ST_BIT) && (qph == 2'd3);
  assign sample    = tick && (st == ST_BIT) && (qph == 2'd1);
  assign byte_done = tick && (st == ST_ACK) && (qph == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      qph       <= 2'd0;
      bcnt      <= FIRST_BIT;
      cur_rd    <= 1'b0;
      cur_last  <= 1'b0;
      ack_hi    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      wr_nack   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      wr_nack   <= 1'b0;
      if (accept) begin
        cur_rd   <= in_rd;
        cur_last <= in_last;
      end
      unique case (st)
        ST_IDLE: begin
          if (in_valid) begin
            st  <= ST_START;
            qph <= 2'd0;
          end
        end
        ST_HOLD: begin
          if (in_valid) begin
            st   <= ST_BIT;
            qph  <= 2'd0;
            bcnt <= FIRST_BIT;
          end
        end
        ST_START: begin
          if (tick) begin
            qph <= qph_nx;
            if (qph == 2'd3) begin
              st   <= ST_BIT;
              bcnt <= FIRST_BIT;
            end
          end
        end
        ST_BIT: begin
          if (tick) begin
            qph <= qph_nx;
            if (qph == 2'd3) begin
              if (bcnt == '0) begin
                st <= ST_ACK;
              end else begin
                bcnt <= bcnt - BIT_CW'(1);
              end
            end
          end
        end
        ST_ACK: begin
          if (tick) begin
            qph <= qph_nx;
            if (qph == 2'd1) begin
              ack_hi <= sda_in;
            end
          end
          if (byte_done) begin
            if (cur_rd) begin
              out_valid <= 1'b1;
              out_data  <= rx_byte;
              out_last  <= cur_last;
            end else begin
              wr_nack <= ack_hi;
            end
            st <= cur_last ? ST_STOP : ST_HOLD;
          end
        end
        ST_STOP: begin
          if (tick) begin
            qph <= qph_nx;
            if (qph == 2'd3) begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign pull   = bus_pull(st, qph, tx_msb, cur_rd, cur_last);
  assign scl_oe = pull[1];
  assign sda_oe = pull[0];

  // R8: an SDA move during SCL high belongs to a START or a STOP
  a_r8_sda_moves_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && (sda_oe != $past(sda_oe)))
      |-> ($past(st) == ST_START || $past(st) == ST_STOP));

  // R10: one request in flight; ready falls after acceptance
  a_r10_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R2: read data is only presented for read requests
  a_r2_output_from_reads: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cur_rd);

  // R7: refusal reports come only from write requests
  a_r7_nack_from_writes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_nack |-> !cur_rd);

  // R3: end flag travels with the read byte
  a_r3_last_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == cur_last));

  // R5: STOP only ever follows a request marked last
  a_r5_stop_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP) |-> cur_last);

endmodule

// File: rtl/i2c_byte_stream.sv
module i2c_byte_stream #(
  parameter int PERIOD_CYC = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_rd,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       wr_nack,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);

  localparam int QTR = i2cs_pkg::quarter_cycles(PERIOD_CYC);

  logic       tick;
  logic       run;
  logic       accept;
  logic       advance;
  logic       sample;
  logic       tx_msb;
  logic [7:0] rx_byte;

  i2cs_qtick #(.QTR(QTR)) u_qtick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  i2cs_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_byte (in_data),
    .advance   (advance),
    .sample    (sample),
    .sda_in    (sda_in),
    .tx_msb    (tx_msb),
    .rx_byte   (rx_byte)
  );

  i2cs_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .in_valid  (in_valid),
    .in_rd     (in_rd),
    .in_last   (in_last),
    .sda_in    (sda_in),
    .tx_msb    (tx_msb),
    .rx_byte   (rx_byte),
    .in_ready  (in_ready),
    .accept    (accept),
    .run       (run),
    .advance   (advance),
    .sample    (sample),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .wr_nack   (wr_nack)
  );

endmodule

// File: tb/test_i2c_byte_stream.sv
`timescale 1ns/1ps
module test_i2c_byte_stream;

  localparam int  PERIOD = 16;
  localparam real TCLK   = 5.0;
  localparam int  NV     = 15;

  // {rd, last, data[7:0], target byte[7:0], target refuses}
  localparam logic [18:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 8'hA4, 8'h00, 1'b0},
    {1'b0, 1'b0, 8'h10, 8'h00, 1'b0},
    {1'b0, 1'b0, 8'h5A, 8'h00, 1'b0},
    {1'b0, 1'b1, 8'hC3, 8'h00, 1'b0},
    {1'b0, 1'b0, 8'hA4, 8'h00, 1'b0},
    {1'b0, 1'b1, 8'h21, 8'h00, 1'b0},
    {1'b0, 1'b0, 8'hA5, 8'h00, 1'b0},
    {1'b1, 1'b0, 8'h00, 8'h96, 1'b0},
    {1'b1, 1'b0, 8'hFF, 8'h3C, 1'b0},
    {1'b1, 1'b1, 8'h00, 8'h81, 1'b0},
    {1'b0, 1'b1, 8'h7E, 8'h00, 1'b1},
    {1'b0, 1'b0, 8'h33, 8'h00, 1'b0},
    {1'b1, 1'b1, 8'h55, 8'h00, 1'b0},
    {1'b0, 1'b0, 8'hB1, 8'h00, 1'b0},
    {1'b1, 1'b1, 8'h00, 8'hFF, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_rd = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_last;
  logic       wr_nack;
  logic       scl_oe;
  logic       sda_oe;
  logic       scl_bus;
  logic       sda_bus;
  logic       tgt_low;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  i2c_byte_stream #(.PERIOD_CYC(PERIOD)) i_i2c_byte_stream (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_rd     (in_rd),
    .in_data   (in_data),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .wr_nack   (wr_nack),
    .sda_in    (sda_bus),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe)
  );

  // ---------------- target model on the open-drain bus ----------------
  logic       t_rd = 1'b0;
  logic [7:0] t_byte = 8'h00;
  logic       t_nack = 1'b0;
  bit         active = 1'b0;
  int         bitpos = 0;
  int         drv_pos = 0;
  logic [7:0] sr = 8'h00;
  logic [7:0] wr_byte = 8'h00;
  logic       ack_bit = 1'b0;
  int         starts = 0;
  int         stops = 0;
  int         ctl_drive_rd = 0;
  int         period_err = 0;
  int         high_err = 0;
  int         periods_meas = 0;
  realtime    t_rise = 0.0;
  logic       p_scl = 1'b1;
  logic       p_sda = 1'b1;

  assign scl_bus = !scl_oe;
  assign sda_bus = !(sda_oe || tgt_low);
  assign tgt_low = active &&
    (((drv_pos < 8) && t_rd && !t_byte[(7 - drv_pos) & 7]) ||
     ((drv_pos == 8) && !t_rd && !t_nack));

  always @(scl_bus or sda_bus) begin
    if (scl_bus && p_scl && p_sda && !sda_bus) begin
      starts++;
      active = 1'b1;
      bitpos = 0;
      drv_pos = 0;
    end else if (scl_bus && p_scl && !p_sda && sda_bus) begin
      stops++;
      active = 1'b0;
    end else if (scl_bus && !p_scl) begin
      if (active) begin
        if (bitpos >= 1 && bitpos <= 8) begin
          periods_meas++;
          if (($realtime - t_rise) > PERIOD * TCLK + 0.1 ||
              ($realtime - t_rise) < PERIOD * TCLK - 0.1) period_err++;
        end
        t_rise = $realtime;
        if (bitpos < 8) begin
          sr = {sr[6:0], sda_bus};
          if (t_rd && sda_oe) ctl_drive_rd++;
          bitpos++;
        end else begin
          ack_bit = sda_bus;
          if (!t_rd) wr_byte = sr;
          if (t_rd && sda_bus) active = 1'b0;
          bitpos = 0;
        end
      end
    end else if (!scl_bus && p_scl) begin
      if (active) begin
        if (bitpos >= 1) begin
          if (($realtime - t_rise) > PERIOD * TCLK / 2.0 + 0.1 ||
              ($realtime - t_rise) < PERIOD * TCLK / 2.0 - 0.1) high_err++;
        end
        drv_pos = bitpos;
      end
    end
    p_scl = scl_bus;
    p_sda = sda_bus;
  end

  // ---------------- output pulse capture ----------------
  int         ov_cnt = 0;
  int         nk_cnt = 0;
  logic [7:0] ov_data = 8'h00;
  logic       ov_last = 1'b0;

  always @(posedge clk) begin
    if (out_valid) begin
      ov_cnt  <= ov_cnt + 1;
      ov_data <= out_data;
      ov_last <= out_last;
    end
    if (wr_nack) nk_cnt <= nk_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_item(input logic rd, input logic last, input logic [7:0] data,
                          input logic [7:0] tb, input logic tn);
    int ov0;
    int nk0;
    while (!in_ready) @(negedge clk);
    t_rd = rd;
    t_byte = tb;
    t_nack = tn;
    ov0 = ov_cnt;
    nk0 = nk_cnt;
    in_rd = rd;
    in_data = data;
    in_last = last;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 ready low while busy", 32'(in_ready), 32'd0);
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    if (rd) begin
      chk("R2 one output pulse for read", 32'(ov_cnt - ov0), 32'd1);
      chk("R2 read byte value", 32'(ov_data), 32'(tb));
      chk("R3 output last flag", 32'(ov_last), 32'(last));
      chk("R6 ninth-clock level on read", 32'(ack_bit), 32'(last));
    end else begin
      chk("R1 byte seen by target", 32'(wr_byte), 32'(data));
      chk("R7 refusal report", 32'(nk_cnt - nk0), 32'(tn));
      chk("R2 no output pulse for write", 32'(ov_cnt - ov0), 32'd0);
    end
    if (!last) begin
      repeat (4) @(negedge clk);
      chk("R10 SCL held low between bytes", 32'(scl_oe), 32'd1);
      chk("R10 ready between bytes", 32'(in_ready), 32'd1);
    end else begin
      chk("R5 lines released after STOP", 32'({scl_oe, sda_oe}), 32'd0);
    end
  endtask

  initial begin
    int exp_txn;
    logic [18:0] v;
    exp_txn = 0;
    repeat (3) @(negedge clk);
    chk("R11 scl released in reset", 32'(scl_oe), 32'd0);
    chk("R11 sda released in reset", 32'(sda_oe), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 ready after reset", 32'(in_ready), 32'd1);
    chk("R11 outputs quiet after reset", 32'({out_valid, wr_nack}), 32'd0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      if (i == 0 || VEC[i-1][17]) exp_txn++;
      run_item(v[18], v[17], v[16:9], v[8:1], v[0]);
    end

    repeat (10) @(negedge clk);
    chk("R4 one START per transaction", 32'(starts), 32'(exp_txn));
    chk("R5 one STOP per transaction", 32'(stops), 32'(exp_txn));
    chk("R8 no stray SDA edge under high SCL", 32'(starts + stops), 32'(2 * exp_txn));
    chk("R2 controller released SDA on read bits", 32'(ctl_drive_rd), 32'd0);
    chk("R9 SCL period", 32'(period_err), 32'd0);
    chk("R9 SCL high time", 32'(high_err), 32'd0);
    chk("R9 periods measured", 32'(periods_meas > 0), 32'd1);

    // Reset during a byte: target stays silent.
    t_rd = 1'b0;
    t_nack = 1'b1;
    in_rd = 1'b0;
    in_data = 8'h00;
    in_last = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk("R1 zero bit pulls SDA mid byte", 32'(sda_oe), 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 lines released on mid-byte reset", 32'({scl_oe, sda_oe}), 32'd0);
    chk("R11 ready on mid-byte reset", 32'(in_ready), 32'd1);
    chk("R11 no pulses on mid-byte reset", 32'({out_valid, wr_nack}), 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R10 watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule